// File: doc/BRIEF.md
# Handshake Bus Synchronizer

This block carries a multi-bit word, typically a configuration setting, from a source clock domain into a destination clock domain whose clock has no known relation to it. The data lines themselves are never resynchronized. The source copies the word into a holding register and then raises a single request level. Only that request bit crosses, through a flip-flop chain clocked by the destination. When the destination sees the request go high, the held word has already been stable for at least two of its cycles. It loads the word into its output register in one step and raises an acknowledge level. The acknowledge crosses back through a chain clocked by the source.

The exchange has four phases: request up, acknowledge up, request down, acknowledge down. The source accepts its next word only after it has seen the acknowledge fall again. A full round trip costs several cycles in each domain, so the block suits slow traffic of about one word every ten or more cycles. It is not meant for one word per clock. Because the whole output register loads on a single edge, the destination never presents a word that mixes bits of the old value and the new one.

Top module: `bus_handshake_sync`

## Requirements
- R1: After reset, `src_ready` is 1, `dst_update` is 0 and `dst_data` is all zeros.
- R2: A word is accepted on a source edge where `src_valid` and `src_ready` are both 1. `src_ready` is 0 on the following source cycle.
- R3: `src_valid` while `src_ready` is 0 is ignored. The word offered at that time never appears at `dst_data`.
- R4: The held word that crosses to the destination stays unchanged while a transfer is in progress, that is, while `src_ready` is 0.
- R5: `dst_data` changes only in a cycle where `dst_update` is 1. `dst_update` lasts one destination cycle per word. Each new output value equals the next accepted word, in acceptance order.
- R6: The request rises only while the acknowledge seen at the source is low. It falls only after that acknowledge is high. `src_ready` returns to 1 only after the acknowledge is seen low again.
- R7: Each accepted word is delivered, and `src_ready` returns, within a bounded number of cycles set by the synchronizer depth. The bench allows 80 source cycles.
- R8: R2 to R7 hold when the destination clock is faster than, equal to, or slower than the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assert |
| src_valid | input | 1 | Source offers a word |
| src_data | input | WIDTH | Word offered by the source |
| src_ready | output | 1 | Source side idle; a word may be accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| dst_data | output | WIDTH | Last word delivered |
| dst_update | output | 1 | One-cycle strobe in the cycle `dst_data` loads |

## Verification
Suppose the source phase register skipped the release phase, or the holding register reloaded while busy. The next word would then overwrite the one in flight. Within one or two transfers the destination would show a word out of order, or `src_ready` would come back before the acknowledge fell. A destination edge detector stuck high would show as back-to-back `dst_update` pulses on the very next destination cycle. A missing capture would show as a word never delivered before the latency bound runs out.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

  // Source-side phase of the four-phase exchange
  typedef enum logic [1:0] {
    SRC_IDLE    = 2'd0,
    SRC_WAIT_HI = 2'd1,
    SRC_WAIT_LO = 2'd2
  } src_phase_t;

  // Rising-level detection on a synchronized control bit
  function automatic logic level_rose(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Next source phase given the acknowledge seen in the source domain
  function automatic src_phase_t src_next(input src_phase_t cur,
                                          input logic take,
                                          input logic ack_seen);
    src_phase_t nxt;
    nxt = cur;
    case (cur)
      SRC_IDLE:    if (take)      nxt = SRC_WAIT_HI;
      SRC_WAIT_HI: if (ack_seen)  nxt = SRC_WAIT_LO;
      SRC_WAIT_LO: if (!ack_seen) nxt = SRC_IDLE;
      default:                    nxt = SRC_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/hsync_level_chain.sv
module hsync_level_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] ff;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[0] <= 1'b0;
          else        ff[0] <= lvl_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[s] <= 1'b0;
          else        ff[s] <= ff[s-1];
        end
      end
    end
  endgenerate

  assign lvl_out = ff[LAST];
endmodule

// File: rtl/hsync_src_side.sv
module hsync_src_side
  import hsync_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [WIDTH-1:0] data,
  input  logic             ack_seen,
  output logic             ready,
  output logic             req_lvl,
  output logic [WIDTH-1:0] held_word
);
  src_phase_t phase_q, phase_d;
  logic       take;

  assign ready   = (phase_q == SRC_IDLE);
  assign take    = valid & ready;
  assign phase_d = src_next(phase_q, take, ack_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= SRC_IDLE;
      req_lvl   <= 1'b0;
      held_word <= '0;
    end else begin
      phase_q <= phase_d;
      if (take) begin
        held_word <= data;
        req_lvl   <= 1'b1;
      end else if (phase_q == SRC_WAIT_HI && ack_seen) begin
        req_lvl   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hsync_dst_side.sv
module hsync_dst_side
  import hsync_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_seen,
  input  logic [WIDTH-1:0] held_word,
  output logic             ack_lvl,
  output logic [WIDTH-1:0] out_word,
  output logic             update
);
  logic req_prev;
  logic capture;

  assign capture = level_rose(req_seen, req_prev);
  assign ack_lvl = req_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      out_word <= '0;
      update   <= 1'b0;
    end else begin
      req_prev <= req_seen;
      update   <= capture;
      if (capture) out_word <= held_word;
    end
  end
endmodule

// File: rtl/bus_handshake_sync.sv
module bus_handshake_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic             src_valid,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_ready,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_update
);
  // Named crossing signals, visible to the bound checker
  logic             req_lvl;
  logic             ack_lvl;
  logic             req_at_dst;
  logic             ack_at_src;
  logic [WIDTH-1:0] held_word;

  hsync_src_side #(.WIDTH(WIDTH)) u_src (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .valid    (src_valid),
    .data     (src_data),
    .ack_seen (ack_at_src),
    .ready    (src_ready),
    .req_lvl  (req_lvl),
    .held_word(held_word)
  );

  hsync_level_chain #(.STAGES(STAGES)) u_req_sync (
    .clk    (dst_clk),
    .rst_n  (dst_rst_n),
    .lvl_in (req_lvl),
    .lvl_out(req_at_dst)
  );

  hsync_dst_side #(.WIDTH(WIDTH)) u_dst (
    .clk      (dst_clk),
    .rst_n    (dst_rst_n),
    .req_seen (req_at_dst),
    .held_word(held_word),
    .ack_lvl  (ack_lvl),
    .out_word (dst_data),
    .update   (dst_update)
  );

  hsync_level_chain #(.STAGES(STAGES)) u_ack_sync (
    .clk    (src_clk),
    .rst_n  (src_rst_n),
    .lvl_in (ack_lvl),
    .lvl_out(ack_at_src)
  );
endmodule

// File: rtl/hsync_checker.sv
module hsync_checker #(
  parameter int WIDTH = 16
) (
  input logic             src_clk,
  input logic             src_rst_n,
  input logic             dst_clk,
  input logic             dst_rst_n,
  input logic             src_ready,
  input logic             req_lvl,
  input logic             ack_at_src,
  input logic             req_at_dst,
  input logic [WIDTH-1:0] held_word,
  input logic [WIDTH-1:0] dst_data,
  input logic             dst_update
);
  // R4: the crossing word is frozen while a transfer is in flight
  assert_held_stable_R4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_ready |=> $stable(held_word));

  // R6: request rises only with acknowledge low
  assert_req_rise_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(req_lvl) |-> !ack_at_src);

  // R6: request falls only after acknowledge seen high
  assert_req_fall_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(req_lvl) |-> ack_at_src);

  // R6: idle only with both control levels low
  assert_ready_idle_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_ready |-> (!req_lvl && !ack_at_src));

  // R5: strobe lasts a single destination cycle
  assert_strobe_single_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_update |=> !dst_update);

  // R5: output word changes only alongside the strobe
  assert_out_stable_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_update |-> $stable(dst_data));

  // R5: a strobe only follows a synchronized request
  assert_strobe_has_req_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_update |-> req_at_dst);
endmodule

bind bus_handshake_sync hsync_checker #(.WIDTH(WIDTH)) u_hsync_checker (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .src_ready (src_ready),
  .req_lvl   (req_lvl),
  .ack_at_src(ack_at_src),
  .req_at_dst(req_at_dst),
  .held_word (held_word),
  .dst_data  (dst_data),
  .dst_update(dst_update)
);

// File: tb/test_bus_handshake_sync.sv
`timescale 1ns/1ps
module test_bus_handshake_sync;
  localparam int W = 16;
  localparam int NV = 12;
  localparam int LAT_MAX = 80;

  // {word, destination half period in ns}
  localparam logic [23:0] VECS [0:NV-1] = '{
    {16'hA5C3, 8'd5},  {16'h0000, 8'd5},  {16'hFFFF, 8'd2},
    {16'h1234, 8'd2},  {16'h8001, 8'd3},  {16'h7FFE, 8'd7},
    {16'hFFFF, 8'd23}, {16'h0F0F, 8'd23}, {16'hF0F0, 8'd4},
    {16'h5555, 8'd11}, {16'hAAAA, 8'd6},  {16'h0001, 8'd5}
  };

  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0;
  logic src_valid = 0;
  logic [W-1:0] src_data = '0;
  logic src_ready, dst_update;
  logic [W-1:0] dst_data;
  int dst_half = 5;

  int checks = 0, fails = 0;
  logic [W-1:0] exp_q [0:NV-1];
  int n_sent = 0, n_seen = 0;
  logic prev_upd = 0;
  int cyc = 0;

  always #5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  bus_handshake_sync #(.WIDTH(W), .STAGES(2)) i_bus_handshake_sync (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_data(dst_data), .dst_update(dst_update)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Destination monitor: order, value and strobe width (R5, R3, R8)
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_update) begin
        if (n_seen < n_sent) begin
          check(dst_data === exp_q[n_seen], "R5 word order", dst_data, exp_q[n_seen]);
        end else begin
          check(1'b0, "R3 undelivered word appeared", dst_data, '0);
        end
        check(!prev_upd, "R5 strobe one cycle", {15'd0, prev_upd}, '0);
        n_seen++;
      end
      prev_upd = dst_update;
    end
  end

  // Watchdog
  always @(posedge src_clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic wait_ready(output int waited);
    waited = 0;
    while (!src_ready && waited < 1000) begin
      @(negedge src_clk);
      waited++;
    end
  endtask

  task automatic send(input logic [W-1:0] w);
    int waited;
    wait_ready(waited);
    src_valid = 1;
    src_data  = w;
    exp_q[n_sent] = w;
    n_sent++;
    @(negedge src_clk);
    check(src_ready == 1'b0, "R2 ready drops after accept", {15'd0, src_ready}, '0);
    // R3: offer a different word while busy
    src_data = ~w ^ 16'h3C3C;
    @(negedge src_clk);
    @(negedge src_clk);
    src_valid = 0;
    wait_ready(waited);
    check(waited + 3 <= LAT_MAX, "R7 ready returns in bound", W'(waited + 3), W'(LAT_MAX));
  endtask

  initial begin
    repeat (3) @(negedge src_clk);
    // R1: reset values
    check(src_ready == 1'b1, "R1 ready at reset", {15'd0, src_ready}, 16'd1);
    check(dst_update == 1'b0, "R1 update at reset", {15'd0, dst_update}, '0);
    check(dst_data == '0, "R1 data at reset", dst_data, '0);
    src_rst_n = 1;
    dst_rst_n = 1;
    repeat (2) @(negedge src_clk);

    // Table walk across clock ratios (R8)
    for (int i = 0; i < NV; i++) begin
      dst_half = int'(VECS[i][7:0]);
      send(VECS[i][23:8]);
      repeat (40) @(negedge src_clk);
      check(n_seen == n_sent, "R7 word delivered", W'(n_seen), W'(n_sent));
      check(dst_data === VECS[i][23:8], "R5 output holds last word", dst_data, VECS[i][23:8]);
    end

    // Directed: no extra word from ignored offers (R3)
    repeat (50) @(negedge src_clk);
    check(n_seen == NV, "R3 no extra words", W'(n_seen), W'(NV));
    check(src_ready == 1'b1, "R6 idle after final transfer", {15'd0, src_ready}, 16'd1);

    // Directed: destination reset clears output, source stays idle (R1)
    dst_rst_n = 0;
    repeat (2) @(negedge src_clk);
    check(dst_data == '0, "R1 data after dst reset", dst_data, '0);
    dst_rst_n = 1;
    repeat (4) @(negedge src_clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule